// File: doc/BRIEF.md
# Bridge Exclusive-Access Lock Controller

This block manages bus-lock state for a two-sided bus bridge. It watches the initiator-side lock and frame strobes, a flag telling whether the initiator's current request heads downstream, and a one-cycle completion event for each forwarded transaction. A completion event carries its direction, whether it was locked, whether it was a posted write, and a two-bit result code. From these inputs it drives the target-side lock strobe and a hold flag that stops the queues from forwarding unlocked traffic. It also returns an abort code when the initiator repeats a locked delayed transaction that had been aborted, pulses a system-error strobe for aborted locked posted writes, and keeps two sticky abort status bits.

The state machine has four states. LK_IDLE: no lock is held. LK_ACQ: lock is being acquired on the first transaction of a sequence. LK_HELD: lock is established. LK_REL: a one-cycle release state. The transitions are as follows. IDLE→ACQ happens when lock and frame are both low and the request goes downstream. ACQ→IDLE happens on a retried first locked completion. ACQ→HELD happens on any other first completion. ACQ or HELD→IDLE happens on a locked posted-write completion after the initiator has released. HELD→REL happens when release has been detected and no locked posted write is outstanding. REL→IDLE is unconditional. Release is detected when lock and frame are both sampled high, and it is remembered until the state returns to idle.

Top module: `bridge_lock_ctrl`

## Requirements
- R1: After reset, tgt_lock_n=1, hold_unlocked=0, serr_n=1, abort_ret=00 and abort_stat=00.
- R2: Locked traffic in the upstream direction (req_down=0, or completions with txn_down=0) never asserts tgt_lock_n or hold_unlocked.
- R3: In idle, init_lock_n=0, init_frame_n=0 and req_down=1 at a clock edge make tgt_lock_n=0 and hold_unlocked=1 after that edge.
- R4: While acquiring, a locked downstream completion with result code 01 (retry) returns to idle: tgt_lock_n=1 and hold_unlocked=0 after that edge.
- R5: Once lock is held, a retry completion leaves tgt_lock_n asserted.
- R6: Once lock is held, further locked completions leave tgt_lock_n asserted while the initiator keeps init_lock_n low.
- R7: init_lock_n high while init_frame_n is still low is not a release, so tgt_lock_n stays low.
- R8: When release is detected with lk_pw_pend=0, tgt_lock_n goes high after that edge while hold_unlocked stays high for that one cycle. hold_unlocked falls on the next edge.
- R9: When release is detected while lk_pw_pend=1, lock stays held. The locked posted-write completion that follows then deasserts tgt_lock_n and hold_unlocked at the same edge.
- R10: A locked delayed completion with result 10 (target abort) or 11 (master abort) is stored. The cycle after the next repeat_req pulse, abort_ret shows that same code for one cycle and then returns to 00.
- R11: abort_stat bit 0 records target aborts and bit 1 records master aborts on locked completions. Each bit stays set until a one is written to the matching bit of stat_clr; a new abort wins over a clear in the same cycle.
- R12: A locked posted-write completion with a target abort pulses serr_n low for one cycle when serr_en=1. A master abort does so only when serr_en=1 and mabort_mode=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| init_lock_n | input | 1 | Initiator-side lock strobe, active low |
| init_frame_n | input | 1 | Initiator-side frame strobe, active low |
| req_down | input | 1 | Current initiator request targets the downstream side |
| txn_valid | input | 1 | One-cycle completion event of a forwarded transaction |
| txn_down | input | 1 | Completed transaction went downstream |
| txn_locked | input | 1 | Completed transaction was issued under lock |
| txn_posted | input | 1 | Completed transaction was a posted write (0 = delayed) |
| txn_result | input | 2 | 00 normal, 01 retry, 10 target abort, 11 master abort |
| lk_pw_pend | input | 1 | A locked posted write is still queued toward the target |
| repeat_req | input | 1 | Initiator repeats the locked delayed transaction |
| serr_en | input | 1 | System-error reporting enable |
| mabort_mode | input | 1 | Report master aborts as system errors |
| stat_clr | input | 2 | Write-one-to-clear strobes for abort_stat |
| tgt_lock_n | output | 1 | Target-side lock strobe, active low |
| hold_unlocked | output | 1 | Hold off forwarding of unlocked transactions |
| abort_ret | output | 2 | Abort code returned on a repeat, 00 when none |
| serr_n | output | 1 | System-error pulse, active low |
| abort_stat | output | 2 | Sticky abort status: bit 0 target, bit 1 master |

## Verification
The bench targets four weak points. The first is a retry on the first locked transaction versus a retry on a later one: a design that treats them alike either never takes the lock or drops it in mid-sequence. The second is release detection with frame still low: if lock high alone counted as a release, the lock would end before the sequence does. The third is a release that arrives while a locked posted write is still queued: an early release would free the target bus before that write lands. The bench also checks that hold_unlocked trails tgt_lock_n by one cycle on the delayed path. The fourth is abort handling: the abort code must come back only on a repeat, serr_n must obey both gating bits, and the status bits must survive until cleared one at a time.

// File: rtl/lock_pkg.sv
package lock_pkg;
    localparam int RES_W  = 2;
    localparam int STAT_W = 2;

    typedef enum logic [1:0] {
        LK_IDLE = 2'd0,
        LK_ACQ  = 2'd1,
        LK_HELD = 2'd2,
        LK_REL  = 2'd3
    } lk_state_e;

    typedef enum logic [RES_W-1:0] {
        RES_OK     = 2'b00,
        RES_RETRY  = 2'b01,
        RES_TABORT = 2'b10,
        RES_MABORT = 2'b11
    } txn_res_e;
endpackage

// File: rtl/lock_fsm.sv
module lock_fsm
    import lock_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 init_lock_n,
    input  logic                 init_frame_n,
    input  logic                 req_down,
    input  logic                 cpl_lk,
    input  logic [RES_W-1:0]     cpl_res,
    input  logic                 cpl_posted,
    input  logic                 lk_pw_pend,
    output lk_state_e            state_o,
    output logic                 tgt_lock_n,
    output logic                 hold
);
    lk_state_e state_q, state_d;
    logic      rel_seen_q, rel_seen_d;
    logic      rel_now, released, retry_cpl, posted_done;

    // Release: lock and frame both sampled high.
    assign rel_now     = init_lock_n && init_frame_n;
    assign released    = rel_now || rel_seen_q;
    assign retry_cpl   = cpl_lk && (cpl_res == RES_RETRY);
    assign posted_done = cpl_lk && !retry_cpl && cpl_posted && released;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_IDLE: if (!init_lock_n && !init_frame_n && req_down) state_d = LK_ACQ;
            LK_ACQ: begin
                if (retry_cpl)        state_d = LK_IDLE;
                else if (posted_done) state_d = LK_IDLE;
                else if (cpl_lk)      state_d = LK_HELD;
            end
            LK_HELD: begin
                if (posted_done)                   state_d = LK_IDLE;
                else if (released && !lk_pw_pend)  state_d = LK_REL;
            end
            LK_REL: state_d = LK_IDLE;
            default: state_d = LK_IDLE;
        endcase
    end

    assign rel_seen_d = ((state_d == LK_ACQ) || (state_d == LK_HELD)) && released;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= LK_IDLE;
            rel_seen_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            rel_seen_q <= rel_seen_d;
        end
    end

    always_comb begin
        tgt_lock_n = 1'b1;
        hold       = 1'b1;
        unique case (state_q)
            LK_IDLE: hold       = 1'b0;
            LK_ACQ:  tgt_lock_n = 1'b0;
            LK_HELD: tgt_lock_n = 1'b0;
            LK_REL:  tgt_lock_n = 1'b1;
            default: hold       = 1'b0;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/abort_trk.sv
module abort_trk
    import lock_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cpl_lk,
    input  logic [RES_W-1:0]     cpl_res,
    input  logic                 cpl_posted,
    input  logic                 repeat_req,
    input  logic                 serr_en,
    input  logic                 mabort_mode,
    input  logic [STAT_W-1:0]    stat_clr,
    output logic [RES_W-1:0]     abort_ret,
    output logic                 serr_n,
    output logic [STAT_W-1:0]    abort_stat
);
    logic [RES_W-1:0]  pend_q;
    logic [STAT_W-1:0] stat_set;
    logic              is_abort, is_tab, is_mab, serr_hit;

    assign is_abort = cpl_lk && ((cpl_res == RES_TABORT) || (cpl_res == RES_MABORT));
    assign is_tab   = is_abort && (cpl_res == RES_TABORT);
    assign is_mab   = is_abort && (cpl_res == RES_MABORT);
    assign stat_set = {is_mab, is_tab};
    assign serr_hit = cpl_posted && serr_en && (is_tab || (is_mab && mabort_mode));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q     <= RES_OK;
            abort_ret  <= RES_OK;
            serr_n     <= 1'b1;
            abort_stat <= '0;
        end else begin
            if (is_abort && !cpl_posted) pend_q <= cpl_res;
            else if (repeat_req)         pend_q <= RES_OK;
            abort_ret  <= repeat_req ? pend_q : RES_OK;
            serr_n     <= !serr_hit;
            abort_stat <= (abort_stat & ~stat_clr) | stat_set;
        end
    end
endmodule

// File: rtl/bridge_lock_ctrl.sv
module bridge_lock_ctrl
    import lock_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init_lock_n,
    input  logic        init_frame_n,
    input  logic        req_down,
    input  logic        txn_valid,
    input  logic        txn_down,
    input  logic        txn_locked,
    input  logic        txn_posted,
    input  logic [1:0]  txn_result,
    input  logic        lk_pw_pend,
    input  logic        repeat_req,
    input  logic        serr_en,
    input  logic        mabort_mode,
    input  logic [1:0]  stat_clr,
    output logic        tgt_lock_n,
    output logic        hold_unlocked,
    output logic [1:0]  abort_ret,
    output logic        serr_n,
    output logic [1:0]  abort_stat
);
    lk_state_e fsm_st;
    logic      cpl_lk;

    // Only downstream locked completions take part in locking.
    assign cpl_lk = txn_valid && txn_down && txn_locked;

    lock_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .init_lock_n  (init_lock_n),
        .init_frame_n (init_frame_n),
        .req_down     (req_down),
        .cpl_lk       (cpl_lk),
        .cpl_res      (txn_result),
        .cpl_posted   (txn_posted),
        .lk_pw_pend   (lk_pw_pend),
        .state_o      (fsm_st),
        .tgt_lock_n   (tgt_lock_n),
        .hold         (hold_unlocked)
    );

    abort_trk u_abort (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpl_lk      (cpl_lk),
        .cpl_res     (txn_result),
        .cpl_posted  (txn_posted),
        .repeat_req  (repeat_req),
        .serr_en     (serr_en),
        .mabort_mode (mabort_mode),
        .stat_clr    (stat_clr),
        .abort_ret   (abort_ret),
        .serr_n      (serr_n),
        .abort_stat  (abort_stat)
    );
endmodule

// File: rtl/lock_chk.sv
module lock_chk
    import lock_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input lk_state_e  st,
    input logic       req_down,
    input logic       txn_valid,
    input logic       txn_down,
    input logic       txn_locked,
    input logic       txn_posted,
    input logic [1:0] txn_result,
    input logic       lk_pw_pend,
    input logic       repeat_req,
    input logic       serr_en,
    input logic       mabort_mode,
    input logic [1:0] stat_clr,
    input logic       tgt_lock_n,
    input logic       hold_unlocked,
    input logic [1:0] abort_ret,
    input logic       serr_n,
    input logic [1:0] abort_stat
);
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (tgt_lock_n && !hold_unlocked && serr_n));

    p_upstream_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == LK_IDLE && !req_down) |=> tgt_lock_n);

    p_lock_implies_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !tgt_lock_n |-> hold_unlocked);

    p_later_retry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == LK_HELD && lk_pw_pend && txn_valid && txn_down && txn_locked
         && txn_result == 2'b01) |=> (st == LK_HELD));

    p_hold_trails_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tgt_lock_n) && hold_unlocked) |=> !hold_unlocked);

    p_ret_on_repeat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_ret != 2'b00) |-> $past(repeat_req));

    p_stat_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_stat[0] && !stat_clr[0]) |=> abort_stat[0]);

    p_serr_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !serr_n |-> $past(txn_valid && txn_down && txn_locked && txn_posted
                          && serr_en && txn_result[1]));

    p_serr_mgate_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && txn_result == 2'b11 && !mabort_mode) |=> serr_n);
endmodule

bind bridge_lock_ctrl lock_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .st            (fsm_st),
    .req_down      (req_down),
    .txn_valid     (txn_valid),
    .txn_down      (txn_down),
    .txn_locked    (txn_locked),
    .txn_posted    (txn_posted),
    .txn_result    (txn_result),
    .lk_pw_pend    (lk_pw_pend),
    .repeat_req    (repeat_req),
    .serr_en       (serr_en),
    .mabort_mode   (mabort_mode),
    .stat_clr      (stat_clr),
    .tgt_lock_n    (tgt_lock_n),
    .hold_unlocked (hold_unlocked),
    .abort_ret     (abort_ret),
    .serr_n        (serr_n),
    .abort_stat    (abort_stat)
);

// File: tb/sim_bridge_lock_ctrl.sv
`timescale 1ns/1ps
module sim_bridge_lock_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       init_lock_n = 1'b1, init_frame_n = 1'b1, req_down = 1'b0;
    logic       txn_valid = 1'b0, txn_down = 1'b0, txn_locked = 1'b0, txn_posted = 1'b0;
    logic [1:0] txn_result = 2'b00;
    logic       lk_pw_pend = 1'b0, repeat_req = 1'b0;
    logic       serr_en = 1'b0, mabort_mode = 1'b0;
    logic [1:0] stat_clr = 2'b00;
    logic       tgt_lock_n, hold_unlocked, serr_n;
    logic [1:0] abort_ret, abort_stat;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    bridge_lock_ctrl u0 (.*);

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic cpl(input logic dn, input logic lk, input logic pw, input logic [1:0] res);
        txn_valid = 1'b1; txn_down = dn; txn_locked = lk; txn_posted = pw; txn_result = res;
        tick();
        txn_valid = 1'b0;
    endtask

    task automatic acquire();
        init_lock_n = 1'b0; init_frame_n = 1'b0; req_down = 1'b1;
        tick();
    endtask

    task automatic t_reset();
        chk("R1 tgt_lock_n", {1'b0, tgt_lock_n}, 2'b01);
        chk("R1 hold", {1'b0, hold_unlocked}, 2'b00);
        chk("R1 serr_n", {1'b0, serr_n}, 2'b01);
        chk("R1 abort_ret", abort_ret, 2'b00);
        chk("R1 abort_stat", abort_stat, 2'b00);
    endtask

    task automatic t_upstream();
        init_lock_n = 1'b0; init_frame_n = 1'b0; req_down = 1'b0;
        tick(); tick();
        chk("R2 no lock upstream", {1'b0, tgt_lock_n}, 2'b01);
        cpl(1'b0, 1'b1, 1'b0, 2'b00);
        chk("R2 no hold upstream", {1'b0, hold_unlocked}, 2'b00);
        init_lock_n = 1'b1; init_frame_n = 1'b1;
        tick();
    endtask

    task automatic t_first_retry();
        acquire();
        chk("R3 lock asserted", {1'b0, tgt_lock_n}, 2'b00);
        chk("R3 hold asserted", {1'b0, hold_unlocked}, 2'b01);
        init_lock_n = 1'b1; init_frame_n = 1'b1;
        cpl(1'b1, 1'b1, 1'b0, 2'b01);
        chk("R4 retry drops lock", {1'b0, tgt_lock_n}, 2'b01);
        chk("R4 retry drops hold", {1'b0, hold_unlocked}, 2'b00);
    endtask

    task automatic t_delayed_seq();
        acquire();
        init_frame_n = 1'b1;
        cpl(1'b1, 1'b1, 1'b0, 2'b00);
        chk("R6 lock held", {1'b0, tgt_lock_n}, 2'b00);
        init_frame_n = 1'b0;
        cpl(1'b1, 1'b1, 1'b0, 2'b01);
        chk("R5 later retry keeps lock", {1'b0, tgt_lock_n}, 2'b00);
        cpl(1'b1, 1'b1, 1'b0, 2'b00);
        chk("R6 second completion keeps lock", {1'b0, tgt_lock_n}, 2'b00);
        init_lock_n = 1'b1;
        tick();
        chk("R7 lock high frame low", {1'b0, tgt_lock_n}, 2'b00);
        init_frame_n = 1'b1;
        tick();
        chk("R8 lock released", {1'b0, tgt_lock_n}, 2'b01);
        chk("R8 hold one more cycle", {1'b0, hold_unlocked}, 2'b01);
        tick();
        chk("R8 hold dropped", {1'b0, hold_unlocked}, 2'b00);
    endtask

    task automatic t_posted_seq();
        acquire();
        cpl(1'b1, 1'b1, 1'b0, 2'b00);
        lk_pw_pend = 1'b1;
        init_lock_n = 1'b1; init_frame_n = 1'b1;
        tick(); tick();
        chk("R9 pending write keeps lock", {1'b0, tgt_lock_n}, 2'b00);
        lk_pw_pend = 1'b0;
        cpl(1'b1, 1'b1, 1'b1, 2'b00);
        chk("R9 lock drops at write end", {1'b0, tgt_lock_n}, 2'b01);
        chk("R9 hold drops at write end", {1'b0, hold_unlocked}, 2'b00);
    endtask

    task automatic t_delayed_abort();
        acquire();
        init_frame_n = 1'b1;
        cpl(1'b1, 1'b1, 1'b0, 2'b10);
        chk("R11 target abort status", abort_stat, 2'b01);
        chk("R10 no early return", abort_ret, 2'b00);
        repeat_req = 1'b1; tick(); repeat_req = 1'b0;
        chk("R10 target abort returned", abort_ret, 2'b10);
        tick();
        chk("R10 return one cycle", abort_ret, 2'b00);
        cpl(1'b1, 1'b1, 1'b0, 2'b11);
        repeat_req = 1'b1; tick(); repeat_req = 1'b0;
        chk("R10 master abort returned", abort_ret, 2'b11);
        chk("R11 both status bits", abort_stat, 2'b11);
        init_lock_n = 1'b1;
        tick(); tick();
        chk("R11 sticky after release", abort_stat, 2'b11);
        stat_clr = 2'b01; tick(); stat_clr = 2'b00;
        chk("R11 clear bit 0 only", abort_stat, 2'b10);
        stat_clr = 2'b10; txn_valid = 1'b1; txn_down = 1'b1; txn_locked = 1'b1;
        txn_posted = 1'b0; txn_result = 2'b11;
        tick();
        txn_valid = 1'b0; stat_clr = 2'b00;
        chk("R11 set wins over clear", abort_stat, 2'b10);
        repeat_req = 1'b1; tick(); repeat_req = 1'b0;
        stat_clr = 2'b11; tick(); stat_clr = 2'b00;
        chk("R11 cleared", abort_stat, 2'b00);
    endtask

    task automatic t_serr();
        serr_en = 1'b1; mabort_mode = 1'b0;
        cpl(1'b1, 1'b1, 1'b1, 2'b10);
        chk("R12 target abort pulse", {1'b0, serr_n}, 2'b00);
        tick();
        chk("R12 pulse one cycle", {1'b0, serr_n}, 2'b01);
        cpl(1'b1, 1'b1, 1'b1, 2'b11);
        chk("R12 master abort gated", {1'b0, serr_n}, 2'b01);
        mabort_mode = 1'b1;
        cpl(1'b1, 1'b1, 1'b1, 2'b11);
        chk("R12 master abort reported", {1'b0, serr_n}, 2'b00);
        serr_en = 1'b0;
        cpl(1'b1, 1'b1, 1'b1, 2'b10);
        chk("R12 enable off", {1'b0, serr_n}, 2'b01);
        serr_en = 1'b1;
        cpl(1'b1, 1'b1, 1'b0, 2'b10);
        chk("R12 delayed abort no serr", {1'b0, serr_n}, 2'b01);
        repeat_req = 1'b1; tick(); repeat_req = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        tick();
        t_reset();
        t_upstream();
        t_first_retry();
        t_delayed_seq();
        t_posted_seq();
        t_delayed_abort();
        t_serr();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule